// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache between a processor load/store port and a memory port that moves one whole line per transaction. A word address is divided, from most to least significant, into a tag, a line index and a word offset within the line. Each line keeps a valid flag, a dirty flag, a stored tag and its data. A lookup hits only when the indexed line is valid and its stored tag matches the address tag.

A mode pin, captured while reset is held, selects one of two write policies. In write-through mode, stores go to memory and a store miss leaves the cache alone. In write-back mode, stores stay in the cache and a store miss first brings the line in. Loads that miss always bring the line in. In write-back mode, a miss whose victim line is dirty first writes that line back and only then fetches the new one. A single access can therefore cost zero, one or two memory transactions.

The processor holds a request and its fields steady until it sees a one-cycle ready pulse, which carries the load data. The memory side raises a request and keeps it and its fields steady until memory returns a one-cycle acknowledge.

Top module: `dmc_cache`

## Requirements
- R1: A load whose line is valid with a matching tag returns that word with a ready pulse one clock after the request is first seen, with no memory transaction.
- R2: Reset clears every valid and dirty flag, so the first access to any line afterwards misses. The mode pin (1 = write-back, 0 = write-through) is captured only during reset, and changing it later has no effect.
- R3: In write-through mode, a store hit updates the cached word and also performs exactly one memory write carrying only the written bytes.
- R4: In write-through mode, a store miss performs exactly one memory write and no read, and it does not allocate: a later load of that address misses.
- R5: In write-back mode, a store hit updates only the cached line, responds one clock after the request, and leaves memory untouched.
- R6: In write-back mode, a miss that displaces a dirty line first writes the whole victim line (every byte enabled) to the victim's address, then reads the new line at the same index: one write followed by one read.
- R7: A miss that displaces a clean or invalid line performs only the line read, with no write-back.
- R8: In write-back mode, a store miss fetches the line and then merges the store into it. The store bytes take the new value, the other words keep the fetched data, and memory is not written.
- R9: A load miss allocates the line in both modes: one line read, then the word is returned, and a repeat load hits.
- R10: Each memory request moves one whole line, and its request, direction and line address stay unchanged until the acknowledge.
- R11: Byte enables (bit i covers data bits 8i+7..8i) select which bytes of the addressed word a store changes, in the cache and in memory.
- R12: Ready is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_mode_i | input | 1 | Write policy select, captured in reset: 1 write-back, 0 write-through |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_be | input | WORD_W/8 | Byte enables for a store |
| cpu_addr | input | ADDR_W | Word address: tag, index, offset |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load data, valid with ready |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 line write, 0 line read |
| mem_addr | output | TAG_W+IDX_W | Line address |
| mem_be | output | LINE_W/8 | Byte enables across the line for writes |
| mem_wdata | output | LINE_W | Line write data |
| mem_rdata | input | LINE_W | Line read data, valid with acknowledge |
| mem_ack | input | 1 | One-cycle memory acknowledge |

## Verification
The bench targets the conflict cases where two addresses share an index. In write-back mode it makes a line dirty and then evicts it, once with a load and once with a store miss. A design that skipped the write-back, or fetched before writing, would leave stale memory words or report the wrong transaction count. It checks that write-through store misses do not allocate, that partial byte enables merge correctly, and that a write-back store miss keeps the untouched fetched words; a bad merge would return wrong load data. It also flips the mode pin after reset, which a design that did not capture the mode would turn into unexpected memory writes.

// File: rtl/dmc_pkg.sv
// Shared definitions for the direct-mapped cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dmc_pkg;
    // Controller states: idle lookup, word write to memory, victim line
    // write-back, and line fill.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRMEM = 2'd1,
        ST_EVICT = 2'd2,
        ST_FILL  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_tags.sv
// Per-line valid, dirty and tag storage with the hit comparator.
// Assumes fill_en and dirty_set are never raised together.
module dmc_tags #(
    parameter int LINES = 8,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             fill_en,
    input  logic             dirty_set,
    output logic             hit,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Flag update: reset clears everything, a fill makes the line valid and clean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag capture on fill; tags need no reset because valid gates them.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= tag;
    end

    // Lookup outputs for the addressed line.
    always_comb begin
        hit       = valid_q[idx] && (tag_q[idx] == tag);
        vic_dirty = valid_q[idx] && dirty_q[idx];
        vic_tag   = tag_q[idx];
    end
endmodule

// File: rtl/dmc_data.sv
// Line data storage with a fill path and a byte-masked merge path.
// Assumes fill_en has priority over wr_en.
module dmc_data #(
    parameter int LINES  = 8,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(LINES),
    localparam int NBYTE = LINE_W / 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              wr_en,
    input  logic [NBYTE-1:0]  wr_mask,
    input  logic [LINE_W-1:0] wr_line,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_W-1:0] line_q [LINES];
    logic [LINE_W-1:0] merged;

    assign rd_line = line_q[idx];

    // Byte-wise merge of store data into the current line contents.
    for (genvar g = 0; g < NBYTE; g++) begin : g_merge
        assign merged[g*8 +: 8] = wr_mask[g] ? wr_line[g*8 +: 8] : rd_line[g*8 +: 8];
    end

    // Line write: whole line on fill, merged line on a store.
    always_ff @(posedge clk) begin
        if (fill_en)    line_q[idx] <= fill_data;
        else if (wr_en) line_q[idx] <= merged;
    end
endmodule

// File: rtl/dmc_ctrl.sv
// Cache controller: decides hit handling, write-through traffic,
// victim write-back and fills. Assumes the processor holds its request
// until ready, and memory acknowledges with a one-cycle pulse.
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wb_mode_i,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       hit,
    input  logic       vic_dirty,
    input  logic       mem_ack,
    output dmc_state_e st_o,
    output logic       fill_en,
    output logic       wr_en,
    output logic       dirty_set,
    output logic       resp_o
);
    dmc_state_e st_q, st_d;
    logic       wb_q;
    logic       resp_d;
    logic       start;

    assign start  = (st_q == ST_IDLE) && cpu_req && !resp_o;
    assign st_o   = st_q;

    // Policy capture: the mode pin is only looked at while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= wb_mode_i;
    end

    // Next-state and control decode.
    always_comb begin
        st_d      = st_q;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        dirty_set = 1'b0;
        resp_d    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            resp_d = 1'b1;
                        end else begin
                            wr_en = 1'b1;
                            if (wb_q) begin
                                dirty_set = 1'b1;
                                resp_d    = 1'b1;
                            end else begin
                                st_d = ST_WRMEM;
                            end
                        end
                    end else if (cpu_we && !wb_q) begin
                        st_d = ST_WRMEM;
                    end else if (vic_dirty) begin
                        st_d = ST_EVICT;
                    end else begin
                        st_d = ST_FILL;
                    end
                end
            end
            ST_WRMEM: if (mem_ack) begin resp_d = 1'b1; st_d = ST_IDLE; end
            ST_EVICT: if (mem_ack) st_d = ST_FILL;
            ST_FILL:  if (mem_ack) begin fill_en = 1'b1; st_d = ST_IDLE; end
            default:  st_d = ST_IDLE;
        endcase
    end

    // State and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            resp_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            resp_o <= resp_d;
        end
    end

    // R1
    ld_hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && hit && !cpu_we |=> resp_o && st_q == ST_IDLE);
    // R5
    wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && hit && cpu_we && wb_q |=> resp_o && st_q == ST_IDLE);
    // R4
    wt_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_q |-> st_q != ST_EVICT);
    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(wb_q));
    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_o |=> !resp_o);
endmodule

// File: rtl/dmc_cache.sv
// Direct-mapped data cache top: address split, storage, controller and
// memory-port steering. Assumes a word-addressed processor port and a
// line-wide memory port with request/acknowledge handshake.
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 8,
    localparam int OFF_W  = $clog2(WORDS_PER_LINE),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int BE_W   = WORD_W / 8,
    localparam int LINE_W = WORD_W * WORDS_PER_LINE,
    localparam int LBYTES = LINE_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wb_mode_i,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [BE_W-1:0]        cpu_be,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [WORD_W-1:0]      cpu_wdata,
    output logic                   cpu_ready,
    output logic [WORD_W-1:0]      cpu_rdata,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [TAG_W+IDX_W-1:0] mem_addr,
    output logic [LBYTES-1:0]      mem_be,
    output logic [LINE_W-1:0]      mem_wdata,
    input  logic [LINE_W-1:0]      mem_rdata,
    input  logic                   mem_ack
);
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic              hit, vic_dirty, fill_en, wr_en, dirty_set, evict;
    logic [TAG_W-1:0]  vic_tag;
    logic [LINE_W-1:0] rd_line, wr_line;
    logic [LBYTES-1:0] wr_mask;
    logic [WORD_W-1:0] rd_word, rdata_q;
    dmc_state_e        st;

    assign {a_tag, a_idx, a_off} = cpu_addr;
    assign wr_line = {WORDS_PER_LINE{cpu_wdata}};
    assign wr_mask = {{(LBYTES-BE_W){1'b0}}, cpu_be} << (32'(a_off) * BE_W);
    assign rd_word = rd_line[32'(a_off) * WORD_W +: WORD_W];

    dmc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .tag(a_tag),
        .fill_en(fill_en), .dirty_set(dirty_set),
        .hit(hit), .vic_dirty(vic_dirty), .vic_tag(vic_tag)
    );

    dmc_data #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
        .clk(clk), .idx(a_idx), .fill_en(fill_en), .fill_data(mem_rdata),
        .wr_en(wr_en), .wr_mask(wr_mask), .wr_line(wr_line), .rd_line(rd_line)
    );

    dmc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wb_mode_i(wb_mode_i), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .hit(hit), .vic_dirty(vic_dirty), .mem_ack(mem_ack),
        .st_o(st), .fill_en(fill_en), .wr_en(wr_en), .dirty_set(dirty_set),
        .resp_o(cpu_ready)
    );

    // Memory-port steering: victim line on eviction, store word otherwise.
    always_comb begin
        evict     = (st == ST_EVICT);
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_WRMEM) || evict;
        mem_addr  = {evict ? vic_tag : a_tag, a_idx};
        mem_be    = evict ? '1 : wr_mask;
        mem_wdata = evict ? rd_line : wr_line;
    end

    // Read data register, loaded alongside the ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (!cpu_ready) rdata_q <= rd_word;
    end
    assign cpu_rdata = rdata_q;

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R6
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack && (&mem_be) |=>
        mem_req && !mem_we && mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0]));
endmodule

// File: tb/test_dmc_cache.sv
// Scoreboard bench for dmc_cache: the driver queues expected responses,
// a monitor pops and compares them on each ready pulse.
module test_dmc_cache;
    localparam int MEMW = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wb_mode = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [3:0]   cpu_be = '0;
    logic [9:0]   cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [7:0]   mem_addr;
    logic [15:0]  mem_be;
    logic [127:0] mem_wdata, mem_rdata;
    logic         mem_ack = 1'b0;

    logic [31:0] mem  [MEMW];
    logic [31:0] gold [MEMW];
    int n_wr = 0, n_rd = 0, lat_cnt = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    bit          ld_q[$];
    string       tg_q[$];

    always #4 clk = ~clk;

    dmc_cache i_dmc_cache (
        .clk(clk), .rst_n(rst_n), .wb_mode_i(wb_mode), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Behavioural line memory with a fixed acknowledge latency.
    always_comb begin
        for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mem[int'(mem_addr)*4 + w];
    end

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt == 2) mem_ack <= 1'b1;
            else lat_cnt <= lat_cnt + 1;
        end
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                n_wr <= n_wr + 1;
                for (int w = 0; w < 4; w++)
                    for (int b = 0; b < 4; b++)
                        if (mem_be[w*4+b])
                            mem[int'(mem_addr)*4 + w][b*8 +: 8] <= mem_wdata[w*32 + b*8 +: 8];
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [9:0] mk(input int t, input int ix, input int o);
        return {5'(t), 3'(ix), 2'(o)};
    endfunction

    // Monitor: compare each response against the head of the scoreboard.
    always @(negedge clk) begin
        logic [31:0] e;
        bit          l;
        string       t;
        if (rst_n && cpu_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 response without request", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                l = ld_q.pop_front();
                t = tg_q.pop_front();
                if (l) check(cpu_rdata === e, t, cpu_rdata, e);
            end
        end
    end

    // Driver: one access, with expected memory writes/reads and latency.
    task automatic access(input bit we, input logic [9:0] a, input logic [3:0] be,
                          input logic [31:0] d, input int ew, input int er,
                          input int elat, input string r);
        int w0, r0, cyc;
        if (we) begin
            for (int b = 0; b < 4; b++) if (be[b]) gold[a][b*8 +: 8] = d[b*8 +: 8];
            exp_q.push_back('0);
            ld_q.push_back(1'b0);
        end else begin
            exp_q.push_back(gold[a]);
            ld_q.push_back(1'b1);
        end
        tg_q.push_back({r, " load data"});
        w0 = n_wr; r0 = n_rd;
        cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = d; cpu_req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 400);
        cpu_req = 1'b0;
        check(cpu_ready, {r, " response seen"}, 32'(cpu_ready), 32'd1);
        if (elat >= 0) check(cyc == elat, {r, " latency"}, 32'(cyc), 32'(elat));
        check(n_wr - w0 == ew, {r, " R10 memory writes"}, 32'(n_wr - w0), 32'(ew));
        check(n_rd - r0 == er, {r, " R10 memory reads"}, 32'(n_rd - r0), 32'(er));
        @(negedge clk);
        check(!cpu_ready, "R12 ready one cycle", 32'(cpu_ready), 32'd0);
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0;
        wb_mode = mode;
        repeat (3) begin
            @(negedge clk);
            check(!cpu_ready && !mem_req, "R2 idle in reset", {cpu_ready, mem_req}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        for (int i = 0; i < MEMW; i++) begin
            mem[i]  = {16'hC0DE ^ 16'(i * 7), 16'(i)};
            gold[i] = {16'hC0DE ^ 16'(i * 7), 16'(i)};
        end

        // Write-through phase
        do_reset(1'b0);
        access(1'b0, mk(1,0,0), 4'hF, 0, 0, 1, -1, "R9 WT load miss fills");
        access(1'b0, mk(1,0,2), 4'hF, 0, 0, 0, 1, "R1 load hit");
        access(1'b1, mk(1,0,1), 4'hF, 32'hAAAA_0001, 1, 0, -1, "R3 WT store hit");
        check(mem[mk(1,0,1)] === 32'hAAAA_0001, "R3 memory written", mem[mk(1,0,1)], 32'hAAAA_0001);
        access(1'b0, mk(1,0,1), 4'hF, 0, 0, 0, 1, "R3 cached word updated");
        access(1'b1, mk(2,1,0), 4'hF, 32'hBBBB_0002, 1, 0, -1, "R4 WT store miss");
        check(mem[mk(2,1,0)] === 32'hBBBB_0002, "R4 memory written", mem[mk(2,1,0)], 32'hBBBB_0002);
        access(1'b0, mk(2,1,0), 4'hF, 0, 0, 1, -1, "R4 no allocate, load misses");
        access(1'b1, mk(1,0,3), 4'b0101, 32'h1122_3344, 1, 0, -1, "R11 partial store");
        check(mem[mk(1,0,3)] === gold[mk(1,0,3)], "R11 memory byte merge", mem[mk(1,0,3)], gold[mk(1,0,3)]);
        access(1'b0, mk(1,0,3), 4'hF, 0, 0, 0, 1, "R11 cached byte merge");
        access(1'b0, mk(3,0,0), 4'hF, 0, 0, 1, -1, "R7 clean conflict eviction");

        // Write-back phase; the mode pin flips after reset and must be ignored.
        do_reset(1'b1);
        access(1'b0, mk(3,0,0), 4'hF, 0, 0, 1, -1, "R2 valid cleared by reset");
        access(1'b0, mk(1,0,0), 4'hF, 0, 0, 1, -1, "R9 WB load miss fills");
        wb_mode = 1'b0;
        access(1'b1, mk(1,0,0), 4'hF, 32'hD00D_0003, 0, 0, 1, "R5 R2 WB store hit");
        check(mem[mk(1,0,0)] !== 32'hD00D_0003, "R5 memory untouched", mem[mk(1,0,0)], 32'd0);
        access(1'b0, mk(1,0,0), 4'hF, 0, 0, 0, 1, "R5 cached store visible");
        access(1'b1, mk(4,2,1), 4'hF, 32'hFEED_0004, 0, 1, -1, "R8 WB store miss");
        check(mem[mk(4,2,1)] !== 32'hFEED_0004, "R8 memory not written", mem[mk(4,2,1)], 32'd0);
        access(1'b0, mk(4,2,1), 4'hF, 0, 0, 0, 1, "R8 merged word");
        access(1'b0, mk(4,2,0), 4'hF, 0, 0, 0, 1, "R8 fetched neighbour kept");
        access(1'b0, mk(5,0,0), 4'hF, 0, 1, 1, -1, "R6 dirty victim on load miss");
        for (int w = 0; w < 4; w++)
            check(mem[mk(1,0,w)] === gold[mk(1,0,w)], "R6 victim line in memory",
                  mem[mk(1,0,w)], gold[mk(1,0,w)]);
        access(1'b0, mk(1,0,0), 4'hF, 0, 0, 1, -1, "R7 clean victim skipped");
        access(1'b1, mk(1,0,2), 4'hF, 32'h5EED_0005, 0, 0, 1, "R5 dirty again");
        access(1'b1, mk(6,0,2), 4'b0011, 32'h0000_7777, 1, 1, -1, "R6 R8 store miss dirty victim");
        check(mem[mk(1,0,2)] === 32'h5EED_0005, "R6 victim word written", mem[mk(1,0,2)], 32'h5EED_0005);
        access(1'b0, mk(6,0,2), 4'hF, 0, 0, 0, 1, "R8 R11 merged after fill");
        finish_up();
    end
endmodule